// File: doc/BRIEF.md
# DTMF Tone Steering and Code Latch

This block is the digital back end of a dual-tone keypad receiver. An upstream frequency detector reports, on every clock, whether it currently recognises a valid tone pair and which of the sixteen pairs it is, as a 4-bit code. The block turns that raw, possibly flickering report into two steering flags. The early flag follows the qualified report with no delay. The delayed flag rises only once a tone has persisted for an acquire guard time. It falls only once the tone has been absent for a release guard time.

The guard timing replaces an analog RC steering network with a clamped up/down counter. The counter charges while a qualified tone is present and discharges while it is absent. An upper threshold sets acquisition. A lower threshold sets release, and the gap between the two gives hysteresis. When a tone is registered, its code is captured into a holding register. That register keeps the code until the next registration and feeds the output pads together with a drive enable. An inhibit input suppresses detection. A power-down input halts the guard logic but keeps the last captured code.

Top module: `dtmf_steer`

## Requirements
- R1: `early_det` equals `tone_valid` AND NOT `inhibit` AND NOT `pdn` in the same cycle, with no register in the path.
- R2: Starting from an empty guard level, `steer_dly` rises at the clock edge that ends the ACQ_LVL-th consecutive cycle with `early_det` high. It stays low after ACQ_LVL-1 such cycles.
- R3: With the guard level full (ACQ_LVL) and `steer_dly` high, `steer_dly` falls at the edge that ends the (ACQ_LVL-REL_LVL+1)-th consecutive cycle with `early_det` low. A dropout one cycle shorter leaves it high.
- R4: `code_out` changes only at a registration, which is a rise of `steer_dly`. A `tone_code` change while `steer_dly` is high is ignored. A burst shorter than the acquire time changes neither `code_out` nor `steer_dly`.
- R5: The guard level moves up by one per cycle with `early_det` high and down by one per cycle without it, clamped to the range 0..ACQ_LVL. A broken burst therefore registers only once the net charge reaches ACQ_LVL.
- R6: `code_oe` equals `oe`. When `code_oe` is low the pads are released, and `code_out` keeps the held code regardless.
- R7: While `inhibit` is high, no tone is registered and `early_det` stays low, even with `tone_valid` high.
- R8: A cycle with `pdn` high empties the guard level and clears `steer_dly` at that edge, and it keeps `code_out`. Afterwards a full ACQ_LVL cycles of tone are needed to register.
- R9: Synchronous active-high `rst` clears the guard level, `steer_dly` and `code_out` to 0.
- R10: The registered code is the 4-bit `tone_code` present in the registering cycle, passed through for all 16 values. The usual keypad encoding is 1-9 for digits 1-9, 10 for 0, 11 for *, 12 for #, 13-15 for A-C and 0 for D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn | input | 1 | Power-down: halts guard logic, keeps code |
| inhibit | input | 1 | Suppresses tone detection |
| oe | input | 1 | Output drive request for the code pads |
| tone_valid | input | 1 | Detector reports a recognised tone pair |
| tone_code | input | 4 | Detector's code for the current pair |
| early_det | output | 1 | Immediate qualified detect flag |
| steer_dly | output | 1 | Guard-timed steering flag |
| code_out | output | 4 | Code of the last registered tone |
| code_oe | output | 1 | Pad drive enable for code_out |

## Verification
The hardest state to reach from the ports is a partially charged guard level. The counter is invisible, and only the timing of the next rise or fall of `steer_dly` reveals it. The stimulus therefore sets up precise levels with interrupted bursts, such as five tone cycles, then a two-cycle gap, then the remainder. It also uses dropouts that end one cycle before release, so that an off-by-one in the clamp or the thresholds shifts a steering edge by a cycle. A behavioural model compares both flags and the code on every clock.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    localparam int CODE_W  = 4;
    localparam int GUARD_W = 8;

    typedef logic [CODE_W-1:0]  tone_code_t;
    typedef logic [GUARD_W-1:0] guard_lvl_t;

    typedef struct packed {
        guard_lvl_t lvl;
        logic       steer;
    } guard_state_t;

    // One step of the clamped up/down guard counter.
    function automatic guard_lvl_t guard_step(input guard_lvl_t lvl,
                                              input logic       charge,
                                              input guard_lvl_t top);
        guard_lvl_t r;
        if (charge) begin
            r = (lvl >= top) ? top : lvl + guard_lvl_t'(1);
        end else begin
            r = (lvl == '0) ? '0 : lvl - guard_lvl_t'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/dtmf_early_qual.sv
module dtmf_early_qual
    import dtmf_steer_pkg::*;
(
    input  logic tone_valid,
    input  logic inhibit,
    input  logic pdn,
    output logic early
);
    assign early = tone_valid & ~inhibit & ~pdn;
endmodule

// File: rtl/dtmf_guard_cnt.sv
module dtmf_guard_cnt
    import dtmf_steer_pkg::*;
#(
    parameter int ACQ_LVL = 8,
    parameter int REL_LVL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn,
    input  logic charge,
    output logic steer,
    output logic load
);
    localparam guard_lvl_t TOP = guard_lvl_t'(ACQ_LVL);
    localparam guard_lvl_t REL = guard_lvl_t'(REL_LVL);

    guard_state_t st_q;
    guard_state_t st_d;
    guard_lvl_t   nxt;

    always_comb begin
        nxt        = guard_step(st_q.lvl, charge, TOP);
        st_d.lvl   = nxt;
        st_d.steer = st_q.steer;
        load       = 1'b0;
        if (!st_q.steer && (nxt == TOP)) begin
            st_d.steer = 1'b1;
            load       = 1'b1;
        end else if (st_q.steer && (nxt < REL)) begin
            st_d.steer = 1'b0;
        end
        if (pdn) begin
            st_d = '0;
            load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign steer = st_q.steer;
endmodule

// File: rtl/dtmf_code_hold.sv
module dtmf_code_hold
    import dtmf_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  tone_code_t code_in,
    output tone_code_t code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= code_in;
        end
    end
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
    import dtmf_steer_pkg::*;
#(
    parameter int ACQ_LVL = 8,
    parameter int REL_LVL = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pdn,
    input  logic       inhibit,
    input  logic       oe,
    input  logic       tone_valid,
    input  logic [3:0] tone_code,
    output logic       early_det,
    output logic       steer_dly,
    output logic [3:0] code_out,
    output logic       code_oe
);
    logic       early;
    logic       load;
    tone_code_t held;

    dtmf_early_qual u_qual (
        .tone_valid (tone_valid),
        .inhibit    (inhibit),
        .pdn        (pdn),
        .early      (early)
    );

    dtmf_guard_cnt #(
        .ACQ_LVL (ACQ_LVL),
        .REL_LVL (REL_LVL)
    ) u_guard (
        .clk    (clk),
        .rst    (rst),
        .pdn    (pdn),
        .charge (early),
        .steer  (steer_dly),
        .load   (load)
    );

    dtmf_code_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .code_in (tone_code),
        .code_q  (held)
    );

    assign early_det = early;
    assign code_out  = held;
    assign code_oe   = oe;
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       pdn,
    input logic       inhibit,
    input logic       early_det,
    input logic       steer_dly,
    input logic [3:0] code_out
);
    AST_EARLY_GATED: assert property (@(posedge clk) disable iff (rst)
        (inhibit || pdn) |-> !early_det);                                   // R7
    AST_PDN_DROPS_STEER: assert property (@(posedge clk) disable iff (rst)
        pdn |=> !steer_dly);                                                // R8
    AST_RISE_AFTER_TONE: assert property (@(posedge clk) disable iff (rst)
        $rose(steer_dly) |-> $past(early_det));                             // R2
    AST_FALL_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        ($fell(steer_dly) && !$past(pdn)) |-> !$past(early_det));           // R3
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$rose(steer_dly) && !$past(rst)) |-> $stable(code_out));          // R4
endmodule

bind dtmf_steer dtmf_steer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pdn       (pdn),
    .inhibit   (inhibit),
    .early_det (early_det),
    .steer_dly (steer_dly),
    .code_out  (code_out)
);

// File: tb/sim_dtmf_steer.sv
module sim_dtmf_steer;
    localparam int ACQ = 8;
    localparam int REL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pdn = 1'b0;
    logic       inhibit = 1'b0;
    logic       oe = 1'b1;
    logic       tone_valid = 1'b0;
    logic [3:0] tone_code = 4'd0;
    logic       early_det;
    logic       steer_dly;
    logic [3:0] code_out;
    logic       code_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    int       m_lvl = 0;
    bit       m_st = 1'b0;
    bit [3:0] m_code = 4'd0;

    always #4 clk = ~clk;

    dtmf_steer #(.ACQ_LVL(ACQ), .REL_LVL(REL)) u0 (
        .clk(clk), .rst(rst), .pdn(pdn), .inhibit(inhibit), .oe(oe),
        .tone_valid(tone_valid), .tone_code(tone_code),
        .early_det(early_det), .steer_dly(steer_dly),
        .code_out(code_out), .code_oe(code_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare the combinational flag, step the model, compare state.
    task automatic cyc(input bit v, input bit [3:0] c, input bit inh, input bit pd,
                       input bit o, input bit r);
        bit e;
        @(negedge clk);
        tone_valid = v; tone_code = c; inhibit = inh; pdn = pd; oe = o; rst = r;
        #1;
        e = v && !inh && !pd;
        if (!r) chk("R1 early_det", int'(early_det), int'(e));
        chk("R6 code_oe", int'(code_oe), int'(o));
        @(posedge clk);
        if (r) begin
            m_lvl = 0; m_st = 1'b0; m_code = 4'd0;
        end else if (pd) begin
            m_lvl = 0; m_st = 1'b0;
        end else begin
            if (e) m_lvl = (m_lvl < ACQ) ? m_lvl + 1 : ACQ;
            else   m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
            if (!m_st && m_lvl == ACQ) begin
                m_st = 1'b1; m_code = c;
            end else if (m_st && m_lvl < REL) begin
                m_st = 1'b0;
            end
        end
        #1;
        chk("R5 model steer_dly", int'(steer_dly), int'(m_st));
        chk("R4 model code_out", int'(code_out), int'(m_code));
    endtask

    task automatic run(input int n, input bit v, input bit [3:0] c,
                       input bit inh, input bit pd);
        for (int i = 0; i < n; i++) cyc(v, c, inh, pd, 1'b1, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 reset steer", int'(steer_dly), 0);
        chk("R9 reset code", int'(code_out), 0);
        run(10, 1'b0, 4'd0, 1'b0, 1'b0);

        // R2: acquire
        run(ACQ - 1, 1'b1, 4'd5, 1'b0, 1'b0);
        chk("R2 steer before acquire", int'(steer_dly), 0);
        run(1, 1'b1, 4'd5, 1'b0, 1'b0);
        chk("R2 steer at acquire", int'(steer_dly), 1);
        chk("R10 code 5", int'(code_out), 5);

        // R4: code change while steered is ignored
        run(4, 1'b1, 4'd9, 1'b0, 1'b0);
        chk("R4 code held while steered", int'(code_out), 5);

        // R3: dropout one short of release keeps steer
        run(ACQ - REL, 1'b0, 4'd0, 1'b0, 1'b0);
        chk("R3 short dropout", int'(steer_dly), 1);
        run(10, 1'b1, 4'd9, 1'b0, 1'b0);
        chk("R4 refill keeps code", int'(code_out), 5);
        run(ACQ - REL, 1'b0, 4'd0, 1'b0, 1'b0);
        chk("R3 before release", int'(steer_dly), 1);
        run(1, 1'b0, 4'd0, 1'b0, 1'b0);
        chk("R3 at release", int'(steer_dly), 0);
        run(10, 1'b0, 4'd0, 1'b0, 1'b0);

        // R4: short burst
        run(ACQ - 1, 1'b1, 4'd12, 1'b0, 1'b0);
        run(10, 1'b0, 4'd0, 1'b0, 1'b0);
        chk("R4 short burst steer", int'(steer_dly), 0);
        chk("R4 short burst code", int'(code_out), 5);

        // R5: broken burst 5 on, 2 off -> level 3, needs 5 more
        run(5, 1'b1, 4'd0, 1'b0, 1'b0);
        run(2, 1'b0, 4'd0, 1'b0, 1'b0);
        run(4, 1'b1, 4'd0, 1'b0, 1'b0);
        chk("R5 partial level", int'(steer_dly), 0);
        run(1, 1'b1, 4'd0, 1'b0, 1'b0);
        chk("R5 net charge registers", int'(steer_dly), 1);
        chk("R10 code 0", int'(code_out), 0);
        run(12, 1'b0, 4'd0, 1'b0, 1'b0);

        // R7: inhibit
        run(12, 1'b1, 4'd15, 1'b1, 1'b0);
        chk("R7 inhibited steer", int'(steer_dly), 0);
        chk("R7 inhibited code", int'(code_out), 0);
        run(ACQ, 1'b1, 4'd15, 1'b0, 1'b0);
        chk("R10 code 15", int'(code_out), 15);

        // R8: power-down
        run(1, 1'b1, 4'd15, 1'b0, 1'b1);
        chk("R8 pdn steer", int'(steer_dly), 0);
        chk("R8 pdn keeps code", int'(code_out), 15);
        run(ACQ - 1, 1'b1, 4'd11, 1'b0, 1'b0);
        chk("R8 full acquire needed", int'(steer_dly), 0);
        run(1, 1'b1, 4'd11, 1'b0, 1'b0);
        chk("R8 reacquire", int'(steer_dly), 1);
        chk("R10 code 11", int'(code_out), 11);

        // R6: pads released, code kept
        cyc(1'b1, 4'd11, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 oe low", int'(code_oe), 0);
        chk("R6 code kept", int'(code_out), 11);

        // R9: reset mid-steer
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 mid reset steer", int'(steer_dly), 0);
        chk("R9 mid reset code", int'(code_out), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule